// File: doc/BRIEF.md
# LFSR Horizontal Timing Generator

This block keeps the horizontal position of a raster line in a 6-bit linear feedback shift register rather than a binary counter. On every clock where counting is enabled the register takes one step along its pseudo-random sequence. Starting from all-zeros, it visits each of 63 distinct codes in a fixed order. A small set of full-width pattern matches picks out particular codes. Those matches move a line-phase state machine, and the state machine drives the horizontal sync, colourburst gate and horizontal blanking levels.

The line length is set by a terminal code. When the register holds that code and counting is enabled, it reloads all-zeros on the next clock. A synchronous restart strobe returns the register and the phase machine to the start of the line whether or not counting is enabled. This lets the same instance serve as a movable object position counter. Every event position is a parameter given as a step count from zero, and the matching code is computed at elaboration.

The phase machine has six states, taken in order along the line:

| State | What it means | Transition out |
|---|---|---|
| PH_LEAD | blank, before sync | to PH_SYNC on a match with step HSYNC_SET |
| PH_SYNC | blank, sync asserted | to PH_GAP on a match with step HSYNC_CLR |
| PH_GAP | blank, between sync and burst | to PH_BURST on a match with step BURST_SET |
| PH_BURST | blank, burst gate asserted | to PH_TAIL on a match with step BURST_CLR |
| PH_TAIL | blank, after burst | to PH_ACTIVE on a match with step BLANK_CLR |
| PH_ACTIVE | visible part of the line | to PH_LEAD on a match with step LINE_END |

Two transitions apply from every state. A match with LINE_END leads to PH_LEAD. A restart strobe also leads to PH_LEAD.

Top module: `hts_line_timer`

## Requirements
- R1: While the asynchronous reset is low, and directly after it is released, the outputs are lfsr_q = 0, hblank = 1, hsync = 0 and burst = 0.
- R2: On each enabled clock that is not the terminal step, bits 5..1 take the old bits 4..0, and bit 0 takes the XNOR of old bits 5 and 4. Starting from zero, the value at position p is therefore the result of p such steps, and lfsr_q never equals 6'b111111.
- R3: When the register holds the code of step LINE_END (default 56) and counting is enabled, the next value is zero. A line therefore lasts LINE_END+1 enabled clocks (57 by default).
- R4: hsync is 1 exactly at positions HSYNC_SET+1 to HSYNC_CLR (default 5 to 8). It rises on the clock after lfsr_q holds the code of step HSYNC_SET.
- R5: burst is 1 exactly at positions BURST_SET+1 to BURST_CLR (default 10 to 12).
- R6: hblank is 1 at positions 0 to BLANK_CLR (default 0 to 16) and 0 from BLANK_CLR+1 to LINE_END. It falls on the clock after lfsr_q holds the code of step BLANK_CLR.
- R7: hsync and burst are never 1 together, and either one is 1 only while hblank is 1.
- R8: While cnt_en is 0 and restart is 0, lfsr_q, hsync, burst and hblank hold their values.
- R9: A restart pulse puts the outputs at position 0 on the next clock (lfsr_q = 0, hblank = 1, hsync = 0, burst = 0), whatever cnt_en is and whatever position the line is at, including the terminal step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | counting clock |
| rst_n | input | 1 | asynchronous reset, active low |
| cnt_en | input | 1 | advance one position on this clock |
| restart | input | 1 | synchronous return to position 0, priority over cnt_en |
| lfsr_q | output | 6 | raw shift-register state |
| hsync | output | 1 | horizontal sync level |
| burst | output | 1 | colourburst gate level |
| hblank | output | 1 | horizontal blanking level |

## Verification
The bench follows the line position in its own model and compares the raw code and all three levels on every clock. The main risk is an off-by-one between a matched code and the level it moves: a design that decoded one step late, or drove the levels straight from the match, would shift every edge by a clock. The line length is measured at the ports. A design that reloaded one state late, or ran the sequence into the excluded all-ones code, would give a line longer than 57 clocks or a register that sticks. Restart is tested with counting disabled and on the terminal step. A design that gave counting priority over restart, or cleared the register but left the phase machine where it was, would show blanking or sync in the wrong place on the following line.

// File: rtl/hts_pkg.sv
package hts_pkg;

    // Width of the position shift register.
    localparam int unsigned POS_W = 6;
    // Number of distinct codes reachable from zero (all-ones is excluded).
    localparam int unsigned POS_STATES = (1 << POS_W) - 1;

    typedef logic [POS_W-1:0] pos_t;

    // Indices into the pattern-match vector.
    localparam int unsigned HIT_N         = 6;
    localparam int unsigned HIT_SYNC_ON   = 0;
    localparam int unsigned HIT_SYNC_OFF  = 1;
    localparam int unsigned HIT_BURST_ON  = 2;
    localparam int unsigned HIT_BURST_OFF = 3;
    localparam int unsigned HIT_ACTIVE    = 4;
    localparam int unsigned HIT_END       = 5;

    typedef enum logic [2:0] {
        PH_LEAD   = 3'd0,
        PH_SYNC   = 3'd1,
        PH_GAP    = 3'd2,
        PH_BURST  = 3'd3,
        PH_TAIL   = 3'd4,
        PH_ACTIVE = 3'd5
    } line_phase_e;

    // One step of the sequence: shift up, XNOR of the two top bits enters at bit 0.
    function automatic pos_t pos_advance(input pos_t s);
        return {s[POS_W-2:0], ~(s[POS_W-1] ^ s[POS_W-2])};
    endfunction

    // Code held after n steps from all-zeros; used to build match constants.
    function automatic pos_t pos_code(input int unsigned n);
        pos_t s;
        s = '0;
        for (int unsigned i = 0; i < n; i++) begin
            s = pos_advance(s);
        end
        return s;
    endfunction

endpackage

// File: rtl/hts_lfsr_counter.sv
module hts_lfsr_counter
    import hts_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic step_en,
    input  logic restart,
    input  logic wrap,
    output pos_t q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (restart) begin
            q <= '0;
        end else if (step_en) begin
            if (wrap) begin
                q <= '0;
            end else begin
                q <= pos_advance(q);
            end
        end
    end

endmodule

// File: rtl/hts_state_decode.sv
module hts_state_decode
    import hts_pkg::*;
#(
    parameter int unsigned         N     = 6,
    parameter logic [N*POS_W-1:0]  CODES = '0
) (
    input  pos_t         state,
    output logic [N-1:0] hit
);

    // One full-width compare per pattern: an AND term over all bits.
    for (genvar i = 0; i < N; i++) begin : g_term
        localparam pos_t PATTERN = CODES[i*POS_W +: POS_W];
        assign hit[i] = (state == PATTERN);
    end

endmodule

// File: rtl/hts_phase_fsm.sv
module hts_phase_fsm
    import hts_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_en,
    input  logic             restart,
    input  logic [HIT_N-1:0] hit,
    output logic             hsync,
    output logic             burst,
    output logic             hblank
);

    line_phase_e cur_ph;
    line_phase_e nxt_ph;

    // Next-state decision from the matched codes.
    always_comb begin
        nxt_ph = cur_ph;
        if (step_en) begin
            if (hit[HIT_END]) begin
                nxt_ph = PH_LEAD;
            end else begin
                unique case (cur_ph)
                    PH_LEAD:   if (hit[HIT_SYNC_ON])   nxt_ph = PH_SYNC;
                    PH_SYNC:   if (hit[HIT_SYNC_OFF])  nxt_ph = PH_GAP;
                    PH_GAP:    if (hit[HIT_BURST_ON])  nxt_ph = PH_BURST;
                    PH_BURST:  if (hit[HIT_BURST_OFF]) nxt_ph = PH_TAIL;
                    PH_TAIL:   if (hit[HIT_ACTIVE])    nxt_ph = PH_ACTIVE;
                    PH_ACTIVE: nxt_ph = PH_ACTIVE;
                    default:   nxt_ph = PH_LEAD;
                endcase
            end
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_ph <= PH_LEAD;
        end else if (restart) begin
            cur_ph <= PH_LEAD;
        end else begin
            cur_ph <= nxt_ph;
        end
    end

    // Output levels, a pure function of the registered phase.
    always_comb begin
        hsync  = 1'b0;
        burst  = 1'b0;
        hblank = 1'b1;
        unique case (cur_ph)
            PH_LEAD:   ;
            PH_SYNC:   hsync  = 1'b1;
            PH_GAP:    ;
            PH_BURST:  burst  = 1'b1;
            PH_TAIL:   ;
            PH_ACTIVE: hblank = 1'b0;
            default:   ;
        endcase
    end

endmodule

// File: rtl/hts_line_timer.sv
module hts_line_timer
    import hts_pkg::*;
#(
    parameter int unsigned HSYNC_SET = 4,
    parameter int unsigned HSYNC_CLR = 8,
    parameter int unsigned BURST_SET = 9,
    parameter int unsigned BURST_CLR = 12,
    parameter int unsigned BLANK_CLR = 16,
    parameter int unsigned LINE_END  = 56
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             restart,
    output logic [POS_W-1:0] lfsr_q,
    output logic             hsync,
    output logic             burst,
    output logic             hblank
);

    // Match patterns, lowest index in the lowest slice.
    localparam logic [HIT_N*POS_W-1:0] MATCH_CODES = {
        pos_code(LINE_END),
        pos_code(BLANK_CLR),
        pos_code(BURST_CLR),
        pos_code(BURST_SET),
        pos_code(HSYNC_CLR),
        pos_code(HSYNC_SET)
    };

    pos_t             pos_q;
    logic [HIT_N-1:0] hit;

    hts_lfsr_counter u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_en (cnt_en),
        .restart (restart),
        .wrap    (hit[HIT_END]),
        .q       (pos_q)
    );

    hts_state_decode #(
        .N     (HIT_N),
        .CODES (MATCH_CODES)
    ) u_dec (
        .state (pos_q),
        .hit   (hit)
    );

    hts_phase_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_en (cnt_en),
        .restart (restart),
        .hit     (hit),
        .hsync   (hsync),
        .burst   (burst),
        .hblank  (hblank)
    );

    assign lfsr_q = pos_q;

endmodule

// File: rtl/hts_line_timer_chk.sv
module hts_line_timer_chk
    import hts_pkg::*;
#(
    parameter int unsigned HSYNC_SET = 4,
    parameter int unsigned BURST_SET = 9,
    parameter int unsigned BLANK_CLR = 16,
    parameter int unsigned LINE_END  = 56
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_en,
    input logic             restart,
    input logic [POS_W-1:0] lfsr_q,
    input logic             hsync,
    input logic             burst,
    input logic             hblank
);

    localparam pos_t SYNC_CODE  = pos_code(HSYNC_SET);
    localparam pos_t BURST_CODE = pos_code(BURST_SET);
    localparam pos_t BLANK_CODE = pos_code(BLANK_CLR);
    localparam pos_t END_CODE   = pos_code(LINE_END);

    // R2
    never_all_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != {POS_W{1'b1}});

    // R3
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !restart && lfsr_q == END_CODE) |=> (lfsr_q == '0));

    // R4
    sync_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hsync) |-> ($past(lfsr_q) == SYNC_CODE));

    // R5
    burst_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(burst) |-> ($past(lfsr_q) == BURST_CODE));

    // R6
    blank_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hblank) |-> ($past(lfsr_q) == BLANK_CODE));

    // R7
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hsync && burst) && (!(hsync || burst) || hblank));

    // R8
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !restart) |=> ($stable(lfsr_q) && $stable(hsync)
                                   && $stable(burst) && $stable(hblank)));

    // R9
    restart_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (lfsr_q == '0 && hblank && !hsync && !burst));

endmodule

bind hts_line_timer hts_line_timer_chk #(
    .HSYNC_SET (HSYNC_SET),
    .BURST_SET (BURST_SET),
    .BLANK_CLR (BLANK_CLR),
    .LINE_END  (LINE_END)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt_en  (cnt_en),
    .restart (restart),
    .lfsr_q  (lfsr_q),
    .hsync   (hsync),
    .burst   (burst),
    .hblank  (hblank)
);

// File: tb/sim_hts_line_timer.sv
module sim_hts_line_timer;
    timeunit 1ns;
    timeprecision 1ps;

    // Default event positions, taken from the requirements.
    localparam int SYNC_ON   = 4;
    localparam int SYNC_OFF  = 8;
    localparam int BURST_ON  = 9;
    localparam int BURST_OFF = 12;
    localparam int BLANK_OFF = 16;
    localparam int LAST_POS  = 56;

    // Stimulus: {enable, restart, cycle count}
    localparam int NVEC = 10;
    localparam logic [9:0] STIM [NVEC] = '{
        {1'b1, 1'b0, 8'd130},
        {1'b0, 1'b0, 8'd6},
        {1'b1, 1'b0, 8'd31},
        {1'b1, 1'b1, 8'd1},
        {1'b1, 1'b0, 8'd20},
        {1'b0, 1'b1, 8'd1},
        {1'b0, 1'b0, 8'd4},
        {1'b1, 1'b0, 8'd70},
        {1'b1, 1'b1, 8'd2},
        {1'b1, 1'b0, 8'd60}
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cnt_en;
    logic       restart;
    logic [5:0] lfsr_q;
    logic       hsync;
    logic       burst;
    logic       hblank;

    int checks = 0;
    int fails  = 0;
    int pos    = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    hts_line_timer u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_en  (cnt_en),
        .restart (restart),
        .lfsr_q  (lfsr_q),
        .hsync   (hsync),
        .burst   (burst),
        .hblank  (hblank)
    );

    // Code at position p: p steps of shift-up with XNOR(bit5, bit4) into bit 0.
    function automatic logic [5:0] model_code(input int p);
        logic [5:0] s;
        s = 6'd0;
        for (int i = 0; i < p; i++) begin
            s = {s[4:0], ~(s[5] ^ s[4])};
        end
        return s;
    endfunction

    task automatic check_val(input string req, input string what,
                             input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d (pos %0d)",
                     req, what, act, exp, pos);
        end
    endtask

    task automatic check_all();
        check_val((pos == 0) ? "R3" : "R2", "lfsr_q", int'(lfsr_q), int'(model_code(pos)));
        check_val("R4", "hsync", int'(hsync), int'(pos > SYNC_ON && pos <= SYNC_OFF));
        check_val("R5", "burst", int'(burst), int'(pos > BURST_ON && pos <= BURST_OFF));
        check_val("R6", "hblank", int'(hblank), int'(pos <= BLANK_OFF));
        check_val("R7", "overlap", int'(hsync && burst), 0);
        check_val("R2", "all-ones", int'(lfsr_q == 6'h3f), 0);
    endtask

    // Drive after a falling edge, let one rising edge pass, then check.
    task automatic tick(input logic en, input logic rs);
        cnt_en  = en;
        restart = rs;
        @(posedge clk);
        if (rs) pos = 0;
        else if (en) pos = (pos == LAST_POS) ? 0 : pos + 1;
        @(negedge clk);
        check_all();
    endtask

    initial begin
        rst_n   = 1'b0;
        cnt_en  = 1'b0;
        restart = 1'b0;
        repeat (3) @(negedge clk);
        // R1 during reset
        check_val("R1", "lfsr_q in reset", int'(lfsr_q), 0);
        check_val("R1", "hblank in reset", int'(hblank), 1);
        check_val("R1", "hsync in reset", int'(hsync), 0);
        check_val("R1", "burst in reset", int'(burst), 0);
        rst_n = 1'b1;
        @(negedge clk);
        pos = 0;
        // R1 after release
        check_all();

        // Table walk
        for (int v = 0; v < NVEC; v++) begin
            for (int c = 0; c < int'(STIM[v][7:0]); c++) begin
                tick(STIM[v][9], STIM[v][8]);
            end
        end

        // R3: measure the line length at the ports
        begin
            int len;
            tick(1'b0, 1'b1);
            len = 0;
            do begin
                tick(1'b1, 1'b0);
                len++;
            end while (lfsr_q != 6'd0 && len < 100);
            check_val("R3", "line length", len, LAST_POS + 1);
        end

        // R8: idle in the active region keeps everything
        while (pos != 30) tick(1'b1, 1'b0);
        begin
            logic [5:0] held;
            held = lfsr_q;
            for (int k = 0; k < 5; k++) tick(1'b0, 1'b0);
            check_val("R8", "held lfsr_q", int'(lfsr_q), int'(held));
            check_val("R8", "held hblank", int'(hblank), 0);
        end

        // R8: idle inside sync keeps sync asserted
        while (pos != 6) tick(1'b1, 1'b0);
        for (int k = 0; k < 4; k++) tick(1'b0, 1'b0);
        check_val("R8", "hsync held", int'(hsync), 1);

        // R9: restart with counting disabled, from inside burst
        while (pos != 11) tick(1'b1, 1'b0);
        tick(1'b0, 1'b1);
        check_val("R9", "lfsr_q after restart", int'(lfsr_q), 0);
        check_val("R9", "burst after restart", int'(burst), 0);
        check_val("R9", "hblank after restart", int'(hblank), 1);

        // R9: restart on the terminal step
        while (pos != LAST_POS) tick(1'b1, 1'b0);
        tick(1'b1, 1'b1);
        check_val("R9", "restart at end", int'(lfsr_q), 0);
        tick(1'b1, 1'b0);
        check_val("R9", "step after restart", int'(lfsr_q), int'(model_code(1)));

        // R3: natural wrap from the terminal step
        while (pos != LAST_POS) tick(1'b1, 1'b0);
        tick(1'b1, 1'b0);
        check_val("R3", "wrap value", int'(lfsr_q), 0);
        check_val("R6", "blank after wrap", int'(hblank), 1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule